// File: doc/BRIEF.md
# Interleaved Histogram Accumulation Engine

This processing element builds one weighted histogram per feature for a group of G features. Each accepted input item carries an 8-bit quantized feature value, used directly as a bin index, and a 32-bit signed weight for the current document. Items arrive as a valid/ready stream with the features of a document in a fixed rotation, so the k-th accepted item always belongs to feature k mod G. The weight is added to the bin at a read-modify-write distance of LAT cycles. Because G exceeds LAT, an item never reads a bin whose update is still in flight. One item is therefore accepted per cycle and the adder pipeline never stalls.

A one-cycle start pulse first writes zero into every entry of the G×256 storage. Accumulation then runs until an item flagged as the last document's last feature is accepted. The engine waits for the adder pipeline to drain and then runs the integral pass. For each feature it walks from bin 255 down to bin 0 and forms the running sum of the bins from the current one up to 255. It writes each running sum back in place and emits it on a valid/ready result stream, together with its feature and bin labels. A consumer that takes every result as it comes receives one result per cycle. A consumer that stalls holds the stream without losing any result.

Top module: `histacc`

## Requirements
- R1: After reset, in_ready and out_valid are low, and they stay low until a start pulse arrives.
- R2: A start pulse zeroes all G×256 entries. in_ready is low in the cycle after start and rises exactly G×256 cycles after that cycle. Contents from an earlier run never appear in later results.
- R3: Counting from start, the k-th accepted item (in_valid and in_ready both high at a clock edge) adds in_weight to bin in_bin of feature k mod G. The addition is two's-complement and wraps modulo 2^32. in_bin spans 0 to 255.
- R4: During accumulation in_ready stays high on every cycle. Back-to-back items are all accepted, including documents that hit the same bin in every feature.
- R5: With G greater than LAT, the accumulation path never reads a storage address in the same cycle that a write to that address commits.
- R6: Accepting an item with in_last high ends accumulation. in_ready is low from the next cycle on, and items offered afterwards have no effect on any result.
- R7: Results come out feature 0 first, in ascending feature order. Within a feature they come out from bin 255 down to bin 0, with out_feat and out_bin naming the entry. out_data is the sum of that feature's bins from out_bin through 255.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_feat and out_bin hold their values. Every result is delivered exactly once.
- R9: When out_ready is held high, out_valid is continuous from the first result to the last: G×256 results in G×256 cycles.
- R10: Once the last result is taken, out_valid and in_ready both stay low until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: clear storage and begin a new run |
| in_valid | input | 1 | Input item offered |
| in_ready | output | 1 | Input item accepted at this edge when in_valid is high |
| in_bin | input | BW (8) | Quantized feature value, used as the bin index |
| in_weight | input | WW (32) | Signed weight of the current document |
| in_last | input | 1 | Marks the final item of the run |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_data | output | WW (32) | Cumulative sum for the labelled bin |
| out_feat | output | clog2(G) | Feature index of the result |
| out_bin | output | BW (8) | Bin index of the result |

## Verification
The hazard check takes two things for granted: G is larger than LAT, and start only arrives as a single-cycle pulse. The stimulus uses the default G of 8 against an adder distance of 6 and raises start for exactly one cycle, always while the engine is idle. The bin-ordering and hold checks assume that the consumer changes out_ready only between clock edges. The bench drives every input at the falling edge and reads outputs there too, so no result depends on the order of processes at the rising edge. The sweeps cover every bin of every feature, wrap-around sums, negative weights and heavy same-bin traffic, under both a steady and a stalling consumer.

// File: rtl/histacc.sv
module histacc #(
  parameter int G   = 8,
  parameter int LAT = 6,
  parameter int BW  = 8,
  parameter int WW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BW-1:0]         in_bin,
  input  logic [WW-1:0]         in_weight,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WW-1:0]         out_data,
  output logic [$clog2(G)-1:0]  out_feat,
  output logic [BW-1:0]         out_bin
);
  localparam int NB    = 1 << BW;
  localparam int DEPTH = G * NB;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(G);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ACC, S_DRN, S_INT} st_t;
  st_t st;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rd_q;
  logic [AW-1:0] cc;
  logic [FW-1:0] fc;

  logic [LAT:1]  pv;
  logic [AW-1:0] pa [1:LAT];
  logic [WW-1:0] pw1;
  logic [WW-1:0] ps [2:LAT];

  logic [FW-1:0] ifeat, pf;
  logic [BW-1:0] ibin, pb;
  logic          idone, pend;
  logic [WW-1:0] acc, isum;

  logic          acc_go, consume, issue, rd_en, we;
  logic [AW-1:0] a_addr, i_addr, c_addr, rd_addr, wa;
  logic [WW-1:0] wd;

  assign in_ready = (st == S_ACC);
  assign acc_go   = in_valid && in_ready;
  assign a_addr   = AW'(int'(fc) * NB + int'(in_bin));
  assign i_addr   = AW'(int'(ifeat) * NB + int'(ibin));
  assign c_addr   = AW'(int'(pf) * NB + int'(pb));
  assign consume  = (st == S_INT) && pend && (!out_valid || out_ready);
  assign issue    = (st == S_INT) && !idone && (!pend || consume);
  assign rd_en    = acc_go || issue;
  assign rd_addr  = (st == S_ACC) ? a_addr : i_addr;
  assign isum     = rd_q + ((pb == BW'(NB - 1)) ? '0 : acc);

  always_comb begin
    we = 1'b0;
    wa = cc;
    wd = '0;
    if (st == S_CLR) begin
      we = 1'b1;
    end else if (pv[LAT]) begin
      we = 1'b1;
      wa = pa[LAT];
      wd = ps[LAT];
    end else if (consume) begin
      we = 1'b1;
      wa = c_addr;
      wd = isum;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    pa[1] <= a_addr;
    pw1   <= in_weight;
    pa[2] <= pa[1];
    ps[2] <= rd_q + pw1;
    for (int k = 3; k <= LAT; k++) begin
      pa[k] <= pa[k-1];
      ps[k] <= ps[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cc        <= '0;
      fc        <= '0;
      pv        <= '0;
      ifeat     <= '0;
      ibin      <= '1;
      pf        <= '0;
      pb        <= '0;
      idone     <= 1'b0;
      pend      <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_feat  <= '0;
      out_bin   <= '0;
    end else if (start) begin
      st        <= S_CLR;
      cc        <= '0;
      fc        <= '0;
      pv        <= '0;
      idone     <= 1'b0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      pv <= {pv[LAT-1:1], acc_go};
      case (st)
        S_CLR: begin
          cc <= cc + 1'b1;
          if (cc == AW'(DEPTH - 1)) st <= S_ACC;
        end
        S_ACC: begin
          if (acc_go) begin
            fc <= (fc == FW'(G - 1)) ? '0 : fc + 1'b1;
            if (in_last) st <= S_DRN;
          end
        end
        S_DRN: begin
          ifeat <= '0;
          ibin  <= '1;
          idone <= 1'b0;
          pend  <= 1'b0;
          if (pv == '0) st <= S_INT;
        end
        S_INT: begin
          if (issue) begin
            pf   <= ifeat;
            pb   <= ibin;
            pend <= 1'b1;
            ibin <= ibin - 1'b1;
            if (ibin == '0) begin
              if (ifeat == FW'(G - 1)) idone <= 1'b1;
              else ifeat <= ifeat + 1'b1;
            end
          end else if (consume) begin
            pend <= 1'b0;
          end
          if (consume) begin
            out_valid <= 1'b1;
            out_data  <= isum;
            out_feat  <= pf;
            out_bin   <= pb;
            acc       <= isum;
          end else if (out_ready) begin
            out_valid <= 1'b0;
          end
          if (idone && !pend && (!out_valid || out_ready)) st <= S_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/histacc_chk.sv
module histacc_chk #(
  parameter int WW = 32,
  parameter int BW = 8,
  parameter int FW = 3,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [WW-1:0] out_data,
  input logic [FW-1:0] out_feat,
  input logic [BW-1:0] out_bin,
  input logic          acc_go,
  input logic [AW-1:0] rd_addr,
  input logic          we,
  input logic [AW-1:0] wa
);
  // R2
  clear_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !in_ready);

  // R5
  raw_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_go && we && (wa == rd_addr)));

  // R6
  last_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !start) |=> !in_ready);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_data) && $stable(out_feat) && $stable(out_bin)));

  // R7
  bin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_bin != '0) && !start) |=>
      (!out_valid || ((out_bin == $past(out_bin) - 1'b1) && (out_feat == $past(out_feat)))));
endmodule

bind histacc histacc_chk #(.WW(WW), .BW(BW), .FW($clog2(G)), .AW($clog2(G * (1 << BW)))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_feat(out_feat), .out_bin(out_bin), .acc_go(acc_go), .rd_addr(rd_addr),
  .we(we), .wa(wa)
);

// File: tb/tb_histacc.sv
`timescale 1ns/1ps
module tb_histacc;
  localparam int G  = 8;
  localparam int NB = 256;

  logic clk = 0, rst_n = 0, start = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0] in_bin = 0;
  logic [31:0] in_weight = 0;
  logic in_ready, out_valid;
  logic [31:0] out_data;
  logic [2:0] out_feat;
  logic [7:0] out_bin;

  int hist [G][NB];
  int checks = 0, errors = 0;
  int stalls, gaps, cyc;
  bit done = 0;

  always #2.5 clk = ~clk;

  histacc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_bin(in_bin), .in_weight(in_weight), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_feat(out_feat), .out_bin(out_bin)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [31:0] w, input bit last);
    in_valid = 1; in_bin = b; in_weight = w; in_last = last;
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
  endtask

  function automatic logic [7:0] bin_of(int mode, int d, int f);
    case (mode)
      0: return 8'((d * 37 + f * 11 + 3) & 255);
      1: return (d % 3 == 0) ? 8'd0 : (d % 3 == 1) ? 8'd255 : 8'(d * 5);
      2: return 8'(f * 3 + 1);
      default: return 8'((d + f * 32) & 255);
    endcase
  endfunction

  function automatic int wt_of(int mode, int d);
    case (mode)
      0: return d * 1000 - 17000;
      1: return (d % 2 == 1) ? -(d * 12345 + 7) : (d * 12345 + 7);
      2: return (d == 0) ? 32'h7fffffff : 1;
      default: return d * 3 - 250;
    endcase
  endfunction

  task automatic feeder(input int mode, input int ndocs, input bit bubbles);
    for (int d = 0; d < ndocs; d++) begin
      int w = wt_of(mode, d);
      for (int f = 0; f < G; f++) begin
        logic [7:0] b = bin_of(mode, d, f);
        if (bubbles && ((d + f) % 5 == 2)) begin
          in_valid = 0; @(negedge clk);
        end
        hist[f][b] += w;
        send(b, 32'(w), (d == ndocs - 1) && (f == G - 1));
      end
    end
    in_valid = 0; in_last = 0;
    // R6: accumulation closed after the flagged item
    chk(in_ready == 0, "R6", "in_ready after last", in_ready, 0);
    if (!bubbles)
      // R4: no refused cycle during an unbroken burst
      chk(stalls == 0, "R4", "stall cycles", stalls, 0);
    // R6: later offers are ignored (results checked by the collector)
    in_valid = 1; in_bin = 8'd5; in_weight = 32'd99999; in_last = 1;
    repeat (20) @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic collector(input bit bp);
    int n = 0, run = 0, f, b;
    bit held = 0, seen = 0;
    logic [31:0] hd; logic [2:0] hf; logic [7:0] hb;
    while (n < G * NB) begin
      @(negedge clk);
      cyc++;
      out_ready = bp ? (((cyc * 5 + 3) % 7) < 4) : 1'b1;
      if (held)
        // R8: stalled result holds
        chk(out_valid && out_data == hd && out_feat == hf && out_bin == hb,
            "R8", "held result", out_data, hd);
      held = 0;
      if (seen && !out_valid) gaps++;
      if (out_valid) begin
        seen = 1;
        if (!out_ready) begin
          held = 1; hd = out_data; hf = out_feat; hb = out_bin;
        end else begin
          f = n / NB; b = NB - 1 - (n % NB);
          run = (b == NB - 1) ? hist[f][b] : run + hist[f][b];
          // R7 (with R3 accumulation and R2 clearing underneath)
          chk(out_data == 32'(run) && out_feat == 3'(f) && out_bin == 8'(b), "R7",
              $sformatf("feat %0d/%0d bin %0d/%0d data", out_feat, f, out_bin, b),
              longint'($signed(out_data)), run);
          n++;
        end
      end
    end
    out_ready = 1;
    if (!bp)
      // R9: steady stream with no gaps
      chk(gaps == 0, "R9", "gap cycles", gaps, 0);
    repeat (3) @(negedge clk);
    // R10: idle after the stream
    chk(out_valid == 0 && in_ready == 0, "R10", "idle out_valid,in_ready",
        {out_valid, in_ready}, 0);
  endtask

  task automatic run_case(input int mode, input int ndocs, input bit bubbles, input bit bp);
    int n = 0;
    for (int f = 0; f < G; f++) for (int b = 0; b < NB; b++) hist[f][b] = 0;
    stalls = 0; gaps = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!in_ready) begin @(negedge clk); n++; end
    // R2: clear length
    chk(n == G * NB, "R2", "clear cycles", n, G * NB);
    fork
      feeder(mode, ndocs, bubbles);
      collector(bp);
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 0 && out_valid == 0, "R1", "reset in_ready,out_valid",
        {in_ready, out_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(in_ready == 0 && out_valid == 0, "R1", "idle before start",
        {in_ready, out_valid}, 0);
    run_case(0, 40, 0, 0);
    run_case(1, 64, 1, 1);
    run_case(2, 2, 0, 0);
    run_case(3, 200, 1, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule